// File: doc/BRIEF.md
# March Memory Self-Test Controller

This block runs a fixed march sequence of word-wide writes and reads over a small external SRAM and checks every read against the value the sequence expects. It drives one memory operation per clock. The memory must return read data combinationally, in the same cycle as the address. Each word is written and read as either all zeros or all ones.

The march has six elements, run in this order: w0, r0w1, r1w0r0, w0r0w1, r1w0, r0. Within an element, the controller carries out that element's sub-operations in turn at one address, then moves to the next address, going upward from 0. A final status step follows the sixth element.

When a read does not match, the controller spends one cycle in a fail-record state. In that cycle it presents the memory identifier captured at start, the failing address, the map of differing bits and the number of differing bits. It also adds that number to a running total, which saturates. It then continues with the next operation, or it freezes until resumed if halt-on-error is set. Control comes from start, stop, resume, clear and halt-on-error inputs, plus a memory identifier field.

Top module: `mbist_march_ctrl`

## Requirements
- R1: While reset is held and after its release, the outputs are at rest: busy, done, halted, log_valid, mem_en and test_fail are 0, and total_cells is 0.
- R2: A start pulse from idle or done makes busy rise on the next cycle. In that same cycle the first operation is issued, a write of 0 to address 0.
- R3: Memory operations follow the element order w0, r0w1, r1w0r0, w0r0w1, r1w0, r0. Each element runs all of its sub-operations at one address before the address increments from 0 to DEPTH-1. Each write drives mem_wdata all zeros for a 0 and all ones for a 1. A fault-free memory sees exactly 12*DEPTH operations.
- R4: A read whose data differs from the expected word is followed by exactly one cycle with log_valid high and no memory access. In that cycle log_addr is the read address, log_bits is read data XOR expected, log_cells is the number of ones in log_bits, and log_mem_id is the identifier sampled with start.
- R5: With halt-on-error clear, the controller resumes with the operation after the failing read, and every mismatching read produces its own log cycle.
- R6: total_cells accumulates log_cells over a run and saturates at 2^CNT_W-1. It never decreases except on clear or start.
- R7: With halt-on-error set, halted rises after the log cycle. While halted, no memory access occurs. A resume pulse continues the sequence.
- R8: Stop returns the controller to idle on the next cycle from any active state. It leaves total_cells, test_fail and the log fields unchanged.
- R9: Clear returns the controller to idle and zeroes total_cells, test_fail, log_bits, log_cells and log_addr.
- R10: After the last r0 element and the status step, done stays high until the next start, stop or clear. test_fail is 1 if any mismatch was logged in the run. A new start zeroes total_cells and test_fail.
- R11: mem_we is only ever high together with mem_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_start | input | 1 | Start a run from idle or done |
| ctl_stop | input | 1 | Abort to idle, keep the log |
| ctl_resume | input | 1 | Leave the halted state |
| ctl_clear | input | 1 | Return to idle and wipe the log |
| ctl_halt_on_err | input | 1 | Freeze after each logged failure |
| ctl_mem_id | input | ID_W | Identifier of the memory under test |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data (all zeros or all ones) |
| mem_rdata | input | DATA_W | Read data, valid in the same cycle |
| busy | output | 1 | A run is active (running, logging or halted) |
| halted | output | 1 | Frozen after a failure |
| done | output | 1 | Run finished |
| test_fail | output | 1 | A mismatch was logged in this run |
| log_valid | output | 1 | Fail-record cycle |
| log_mem_id | output | ID_W | Identifier of the failing memory |
| log_addr | output | ADDR_W | Failing address |
| log_bits | output | DATA_W | Failing bit positions |
| log_cells | output | CELL_W | Faulty cells in the failing read |
| total_cells | output | CNT_W | Saturating total of faulty cells |

## Verification
The bench uses stuck-at faults that make different reads fail, and checks the exact order of operations cycle by cycle. A design that skipped a sub-operation, or walked the address in the wrong direction, breaks the trace. One that dropped the rest of an address after a failure would issue too few operations and log too few events.

Filling every cell with a fault pushes the total past its maximum. A wrapping counter would end at a small value instead of the saturated one.

Halting, stopping mid-run and restarting after a failing run are driven directly. They expose memory accesses made while frozen, a log lost on stop, and a fail flag that survives a new start.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   localparam int NUM_ELEM = 6;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RUN  = 3'd1,
      ST_FAIL = 3'd2,
      ST_HALT = 3'd3,
      ST_DONE = 3'd4
   } mbist_state_e;

   typedef struct packed {
      logic is_read;
      logic value;
   } march_op_t;

   // number of sub-operations per element
   function automatic logic [1:0] elem_len(input logic [2:0] e);
      case (e)
         3'd0:    return 2'd1;
         3'd1:    return 2'd2;
         3'd2:    return 2'd3;
         3'd3:    return 2'd3;
         3'd4:    return 2'd2;
         default: return 2'd1;
      endcase
   endfunction

   // sub-operation i of element e
   function automatic march_op_t elem_op(input logic [2:0] e, input logic [1:0] i);
      march_op_t op;
      op = '{is_read: 1'b0, value: 1'b0};
      case (e)
         3'd1: op = (i == 2'd0) ? '{1'b1, 1'b0} : '{1'b0, 1'b1};
         3'd2: case (i)
                  2'd0:    op = '{1'b1, 1'b1};
                  2'd1:    op = '{1'b0, 1'b0};
                  default: op = '{1'b1, 1'b0};
               endcase
         3'd3: case (i)
                  2'd0:    op = '{1'b0, 1'b0};
                  2'd1:    op = '{1'b1, 1'b0};
                  default: op = '{1'b0, 1'b1};
               endcase
         3'd4: op = (i == 2'd0) ? '{1'b1, 1'b1} : '{1'b0, 1'b0};
         3'd5: op = '{1'b1, 1'b0};
         default: op = '{1'b0, 1'b0};
      endcase
      return op;
   endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
   import mbist_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              step,
   output logic [2:0]        elem,
   output logic [1:0]        op_idx,
   output logic [ADDR_W-1:0] addr,
   output logic              at_end
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

   logic last_op;

   assign at_end  = (elem == 3'(NUM_ELEM));
   assign last_op = (op_idx == 2'(elem_len(elem) - 2'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elem   <= '0;
         op_idx <= '0;
         addr   <= '0;
      end else if (restart) begin
         elem   <= '0;
         op_idx <= '0;
         addr   <= '0;
      end else if (step && !at_end) begin
         if (last_op) begin
            op_idx <= '0;
            if (addr == LAST_ADDR) begin
               addr <= '0;
               elem <= elem + 3'd1;
            end else begin
               addr <= addr + 1'b1;
            end
         end else begin
            op_idx <= op_idx + 2'd1;
         end
      end
   end

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
   parameter int DATA_W = 8,
   parameter int CELL_W = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0] rdata,
   input  logic              expect_bit,
   output logic [DATA_W-1:0] diff,
   output logic [CELL_W-1:0] cells,
   output logic              mismatch
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign diff[b] = rdata[b] ^ expect_bit;
   end

   always_comb begin
      cells = '0;
      for (int b = 0; b < DATA_W; b++) begin
         cells = cells + CELL_W'(diff[b]);
      end
   end

   assign mismatch = |diff;

endmodule

// File: rtl/mbist_faillog.sv
module mbist_faillog #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int ID_W      = 4,
   parameter int CELL_W    = 4,
   parameter int CNT_W     = 8,
   parameter int MAX_TOTAL = 768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wipe,
   input  logic              capture,
   input  logic [ID_W-1:0]   id_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] diff_in,
   input  logic [CELL_W-1:0] cells_in,
   output logic [ID_W-1:0]   rec_id,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [DATA_W-1:0] rec_bits,
   output logic [CELL_W-1:0] rec_cells,
   output logic [CNT_W-1:0]  total,
   output logic              any_fail
);

   localparam bit NEEDS_SAT = (CNT_W < 32) && ((64'd1 << CNT_W) <= 64'(MAX_TOTAL));

   logic [CNT_W:0]   sum_w;
   logic [CNT_W-1:0] next_total;

   assign sum_w = {1'b0, total} + (CNT_W + 1)'(cells_in);

   if (NEEDS_SAT) begin : g_sat
      assign next_total = sum_w[CNT_W] ? {CNT_W{1'b1}} : sum_w[CNT_W-1:0];
   end else begin : g_wide
      assign next_total = sum_w[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_id    <= '0;
         rec_addr  <= '0;
         rec_bits  <= '0;
         rec_cells <= '0;
         total     <= '0;
         any_fail  <= 1'b0;
      end else if (wipe) begin
         rec_id    <= '0;
         rec_addr  <= '0;
         rec_bits  <= '0;
         rec_cells <= '0;
         total     <= '0;
         any_fail  <= 1'b0;
      end else if (capture) begin
         rec_id    <= id_in;
         rec_addr  <= addr_in;
         rec_bits  <= diff_in;
         rec_cells <= cells_in;
         total     <= next_total;
         any_fail  <= 1'b1;
      end
   end

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
   import mbist_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH),
   parameter int DATA_W = 8,
   parameter int ID_W   = 4,
   parameter int CNT_W  = 8,
   parameter int CELL_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_start,
   input  logic              ctl_stop,
   input  logic              ctl_resume,
   input  logic              ctl_clear,
   input  logic              ctl_halt_on_err,
   input  logic [ID_W-1:0]   ctl_mem_id,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              halted,
   output logic              done,
   output logic              test_fail,
   output logic              log_valid,
   output logic [ID_W-1:0]   log_mem_id,
   output logic [ADDR_W-1:0] log_addr,
   output logic [DATA_W-1:0] log_bits,
   output logic [CELL_W-1:0] log_cells,
   output logic [CNT_W-1:0]  total_cells
);

   localparam int READS_PER_ADDR = 6;
   localparam int MAX_TOTAL      = READS_PER_ADDR * DEPTH * DATA_W;

   if (DEPTH < 2) begin : g_bad_depth
      $error("mbist_march_ctrl: DEPTH must be at least 2");
   end
   if (DEPTH > (1 << ADDR_W)) begin : g_bad_addr
      $error("mbist_march_ctrl: ADDR_W too narrow for DEPTH");
   end
   if (CELL_W > CNT_W) begin : g_bad_cnt
      $error("mbist_march_ctrl: CNT_W must be at least CELL_W");
   end

   mbist_state_e      state, state_nx;
   logic [ID_W-1:0]   run_id;
   logic [2:0]        seq_elem;
   logic [1:0]        seq_op;
   logic [ADDR_W-1:0] seq_addr;
   logic              seq_end;
   march_op_t         cur;
   logic              step, start_go, capture, wipe;
   logic [DATA_W-1:0] diff;
   logic [CELL_W-1:0] cells;
   logic              mismatch;

   assign cur      = elem_op(seq_elem, seq_op);
   assign start_go = ((state == ST_IDLE) || (state == ST_DONE)) && ctl_start
                     && !ctl_clear && !ctl_stop;
   assign step     = (state == ST_RUN) && !seq_end && !ctl_clear && !ctl_stop;
   assign capture  = step && cur.is_read && mismatch;
   assign wipe     = ctl_clear || start_go;

   mbist_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_go),
      .step    (step),
      .elem    (seq_elem),
      .op_idx  (seq_op),
      .addr    (seq_addr),
      .at_end  (seq_end)
   );

   mbist_cmp #(.DATA_W(DATA_W), .CELL_W(CELL_W)) u_cmp (
      .rdata      (mem_rdata),
      .expect_bit (cur.value),
      .diff       (diff),
      .cells      (cells),
      .mismatch   (mismatch)
   );

   mbist_faillog #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .CELL_W(CELL_W), .CNT_W(CNT_W), .MAX_TOTAL(MAX_TOTAL)
   ) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .wipe      (wipe),
      .capture   (capture),
      .id_in     (run_id),
      .addr_in   (seq_addr),
      .diff_in   (diff),
      .cells_in  (cells),
      .rec_id    (log_mem_id),
      .rec_addr  (log_addr),
      .rec_bits  (log_bits),
      .rec_cells (log_cells),
      .total     (total_cells),
      .any_fail  (test_fail)
   );

   always_comb begin
      state_nx = state;
      if (ctl_clear) begin
         state_nx = ST_IDLE;
      end else if (ctl_stop) begin
         state_nx = ST_IDLE;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: if (ctl_start) state_nx = ST_RUN;
            ST_RUN: begin
               if (seq_end)      state_nx = ST_DONE;
               else if (capture) state_nx = ST_FAIL;
            end
            ST_FAIL: state_nx = ctl_halt_on_err ? ST_HALT : ST_RUN;
            ST_HALT: if (ctl_resume) state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         run_id <= '0;
      end else begin
         state <= state_nx;
         if (start_go) run_id <= ctl_mem_id;
      end
   end

   assign mem_en    = step;
   assign mem_we    = step && !cur.is_read;
   assign mem_addr  = seq_addr;
   assign mem_wdata = {DATA_W{cur.value}};
   assign busy      = (state == ST_RUN) || (state == ST_FAIL) || (state == ST_HALT);
   assign halted    = (state == ST_HALT);
   assign done      = (state == ST_DONE);
   assign log_valid = (state == ST_FAIL);

endmodule

module mbist_march_ctrl_chk #(
   parameter int DATA_W = 8,
   parameter int CELL_W = 4,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_start,
   input logic              ctl_stop,
   input logic              ctl_resume,
   input logic              ctl_clear,
   input logic              mem_en,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              busy,
   input logic              halted,
   input logic              done,
   input logic              test_fail,
   input logic              log_valid,
   input logic [DATA_W-1:0] log_bits,
   input logic [CELL_W-1:0] log_cells,
   input logic [CNT_W-1:0]  total_cells
);

   assert_we_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en);

   assert_wdata_solid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ((mem_wdata == '0) || (mem_wdata == '1)));

   assert_log_record_R4: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> ((log_bits != '0) && ($countones(log_bits) == int'(log_cells))));

   assert_log_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> !mem_en);

   assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_en);

   assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !ctl_resume && !ctl_stop && !ctl_clear) |=> halted);

   assert_total_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_clear && !(ctl_start && !busy)) |=> (total_cells >= $past(total_cells)));

   assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_stop && !ctl_clear) |=> (!busy && !done));

   assert_clear_wipes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_clear |=> ((total_cells == '0) && !test_fail));

   assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, done}));

   assert_fail_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (test_fail == (total_cells != '0)));

endmodule

bind mbist_march_ctrl mbist_march_ctrl_chk #(
   .DATA_W(DATA_W), .CELL_W(CELL_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/mbist_march_ctrl_test.sv
`timescale 1ns/1ps
module mbist_march_ctrl_test;

   localparam int D  = 16;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int IW = 4;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_start = 0, ctl_stop = 0, ctl_resume = 0, ctl_clear = 0, ctl_halt_on_err = 0;
   logic [IW-1:0] ctl_mem_id = '0;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          busy, halted, done, test_fail, log_valid;
   logic [IW-1:0] log_mem_id;
   logic [AW-1:0] log_addr;
   logic [DW-1:0] log_bits;
   logic [3:0]    log_cells;
   logic [CW-1:0] total_cells;

   logic [DW-1:0] mem [D];
   logic [DW-1:0] sa0 [D];
   logic [DW-1:0] sa1 [D];

   int n_chk = 0, n_fail = 0;
   int trace_k = 0, trace_err = 0, log_events = 0, log_err = 0, mem_cnt = 0;
   logic [IW-1:0] cur_id = '0;

   always #2.5 clk = ~clk;

   mbist_march_ctrl uut (.*);

   assign mem_rdata = (mem[mem_addr] & ~sa0[mem_addr]) | sa1[mem_addr];

   always @(posedge clk) if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;

   function automatic int pop8(input logic [DW-1:0] v);
      int c = 0;
      for (int b = 0; b < DW; b++) c += int'(v[b]);
      return c;
   endfunction

   function automatic int ops_per(input int e);
      case (e) 0: return 1; 1: return 2; 2: return 3; 3: return 3; 4: return 2; default: return 1; endcase
   endfunction

   // 0 = write 0, 1 = write 1, 2 = read 0, 3 = read 1
   function automatic int op_code(input int e, input int i);
      case (e * 4 + i)
         4: return 2;  5: return 1;
         8: return 3;  9: return 0; 10: return 2;
         12: return 0; 13: return 2; 14: return 1;
         16: return 3; 17: return 0;
         20: return 2;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_code(input int k, output int addr);
      int rem = k;
      for (int e = 0; e < 6; e++) begin
         int span = D * ops_per(e);
         if (rem < span) begin
            addr = rem / ops_per(e);
            return op_code(e, rem % ops_per(e));
         end
         rem -= span;
      end
      addr = -1;
      return -1;
   endfunction

   function automatic int exp_total();
      int s = 0;
      for (int a = 0; a < D; a++) s += 4 * pop8(sa1[a]) + 2 * pop8(sa0[a]);
      return (s > 255) ? 255 : s;
   endfunction

   function automatic int exp_events();
      int s = 0;
      for (int a = 0; a < D; a++) s += 4 * int'(sa1[a] != 0) + 2 * int'(sa0[a] != 0);
      return s;
   endfunction

   // monitor, away from the active edge
   always @(negedge clk) begin
      int ea, code;
      if (ctl_start) begin
         trace_k = 0; trace_err = 0; log_events = 0; log_err = 0;
      end
      if (mem_en) begin
         code = exp_code(trace_k, ea);
         if (code < 0 || mem_we != (code < 2) || int'(mem_addr) != ea ||
             (code < 2 && mem_wdata != {DW{code[0]}}))
            trace_err++;
         trace_k++;
         mem_cnt++;
      end
      if (log_valid) begin
         log_events++;
         if (log_bits == 0 || !(log_bits == sa1[log_addr] || log_bits == sa0[log_addr]) ||
             int'(log_cells) != pop8(log_bits) || log_mem_id != cur_id)
            log_err++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive_edge();
      @(posedge clk); #1;
   endtask

   task automatic clear_faults();
      for (int a = 0; a < D; a++) begin sa0[a] = '0; sa1[a] = '0; end
   endtask

   task automatic pulse_start(input logic [IW-1:0] id, input bit halt);
      drive_edge();
      cur_id = id; ctl_mem_id = id; ctl_halt_on_err = halt; ctl_start = 1'b1;
      drive_edge();
      ctl_start = 1'b0;
   endtask

   task automatic wait_for(input int which, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if ((which == 0 && done) || (which == 1 && halted)) begin ok = 1'b1; break; end
      end
   endtask

   task automatic check_run(input string tag);
      chk(trace_err == 0, "R3", {tag, " op trace errors"}, trace_err, 0);
      chk(log_err == 0, "R4", {tag, " log record errors"}, log_err, 0);
      chk(log_events == exp_events(), "R5", {tag, " log events"}, log_events, exp_events());
      chk(int'(total_cells) == exp_total(), "R6", {tag, " total cells"}, int'(total_cells), exp_total());
      chk(test_fail == (exp_events() != 0), "R10", {tag, " fail flag"}, int'(test_fail), int'(exp_events() != 0));
   endtask

   initial begin
      #750000;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      bit ok;
      int tot, m0;
      void'($urandom(32'd4711));
      clear_faults();
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !halted && !mem_en && !log_valid && !test_fail && total_cells == 0,
          "R1", "outputs during reset", int'(busy | done | mem_en), 0);
      drive_edge(); rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_en && total_cells == 0, "R1", "outputs after reset", int'(busy | mem_en), 0);

      // R2/R3: fault-free run
      m0 = mem_cnt;
      pulse_start(4'h3, 1'b0);
      @(negedge clk);
      chk(busy, "R2", "busy after start", int'(busy), 1);
      wait_for(0, ok);
      chk(ok, "R10", "clean run done", int'(ok), 1);
      chk(mem_cnt - m0 == 12 * D, "R3", "operation count", mem_cnt - m0, 12 * D);
      check_run("clean");

      // R4/R5: single stuck-at-1
      sa1[3] = 8'h04;
      pulse_start(4'h9, 1'b0);
      wait_for(0, ok);
      chk(ok, "R10", "single fault done", int'(ok), 1);
      chk(int'(log_addr) == 3 && log_bits == 8'h04 && log_mem_id == 4'h9, "R4", "last record addr",
          int'(log_addr), 3);
      check_run("single");

      // R5: random faults
      for (int r = 0; r < 4; r++) begin
         clear_faults();
         for (int f = 0; f < 3; f++) begin
            int a = int'($urandom % D);
            sa1[a] = 8'($urandom) & 8'($urandom);
            sa0[a] = 8'($urandom) & ~sa1[a];
         end
         pulse_start(4'($urandom), 1'b0);
         wait_for(0, ok);
         chk(ok, "R10", "random run done", int'(ok), 1);
         check_run("random");
      end

      // R6: saturation
      clear_faults();
      for (int a = 0; a < D; a++) sa1[a] = 8'hFF;
      pulse_start(4'h1, 1'b0);
      wait_for(0, ok);
      chk(total_cells == 8'hFF, "R6", "saturated total", int'(total_cells), 255);
      check_run("saturate");

      // R10: restart clears total and flag
      clear_faults();
      pulse_start(4'h2, 1'b0);
      @(negedge clk);
      chk(total_cells == 0 && !test_fail && !done, "R10", "restart wipes total", int'(total_cells), 0);
      wait_for(0, ok);
      chk(ok && !test_fail, "R10", "clean after restart", int'(test_fail), 0);

      // R7: halt on error
      sa0[5] = 8'h80;
      pulse_start(4'h5, 1'b1);
      wait_for(1, ok);
      chk(ok && log_events == 1 && log_addr == 5 && log_bits == 8'h80, "R7", "first halt", log_events, 1);
      m0 = mem_cnt;
      repeat (6) @(negedge clk);
      chk(halted && mem_cnt == m0, "R7", "quiet while halted", mem_cnt - m0, 0);
      drive_edge(); ctl_resume = 1'b1; drive_edge(); ctl_resume = 1'b0;
      wait_for(1, ok);
      chk(ok && log_events == 2, "R7", "second halt", log_events, 2);
      drive_edge(); ctl_resume = 1'b1; drive_edge(); ctl_resume = 1'b0;
      wait_for(0, ok);
      chk(ok && int'(total_cells) == 2, "R7", "halted run total", int'(total_cells), 2);
      check_run("halt");

      // R8: stop mid-run keeps log
      clear_faults();
      sa1[0] = 8'h01;
      pulse_start(4'h6, 1'b0);
      repeat (40) @(negedge clk);
      tot = int'(total_cells);
      chk(tot > 0 && busy, "R8", "fails before stop", tot, 1);
      drive_edge(); ctl_stop = 1'b1; drive_edge(); ctl_stop = 1'b0;
      @(negedge clk);
      chk(!busy && !done && int'(total_cells) == tot && test_fail, "R8", "after stop total",
          int'(total_cells), tot);
      m0 = mem_cnt;
      repeat (4) @(negedge clk);
      chk(mem_cnt == m0, "R8", "no access when stopped", mem_cnt - m0, 0);

      // R9: clear wipes
      drive_edge(); ctl_clear = 1'b1; drive_edge(); ctl_clear = 1'b0;
      @(negedge clk);
      chk(total_cells == 0 && !test_fail && log_bits == 0 && log_cells == 0 && log_addr == 0 && !busy,
          "R9", "clear wipes log", int'(total_cells), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule